// File: doc/BRIEF.md
# Serial Transmit Framer

This block turns bytes written by a host into asynchronous serial frames on a single output line. Bytes go into a small first-in first-out queue. A frame engine takes them one at a time and sends a start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period. Word length, stop length and parity mode come from static line-control inputs. The engine captures them at the moment it takes a byte from the queue.

Bit timing comes from a single-cycle enable pulse, `tick16`, that runs at sixteen times the bit rate. Each data, start or parity bit lasts `OVERSAMPLE` ticks. A break input pulls the line low for as long as it is held. Two status outputs tell the host whether it may write more bytes and whether the line has fully drained. A clear strobe empties the queue without cutting short the frame already on the line.

Top module: `serial_tx_framer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `txd` is 1 and both `thr_empty` and `tx_idle` are 1.
- R2: A frame is a start bit of 0 and then the data bits, least significant first. The number of data bits is 5, 6, 7 or 8 for `word_len` = 00, 01, 10 or 11. Each of these bits lasts exactly `OVERSAMPLE` rising edges with `tick16` high, and the line idles at 1.
- R3: With `stop_long` = 0 the stop period is 1 bit (`OVERSAMPLE` ticks) at level 1. With `stop_long` = 1 it is 1.5 bits (`OVERSAMPLE*3/2` ticks) when the word length is 5, and 2 bits (`2*OVERSAMPLE` ticks) for 6, 7 or 8 data bits.
- R4: For {`par_stick`,`par_even`,`par_en`}, the parity bit follows the last data bit and lasts one bit time. Code 001 gives odd parity over the sent data bits, 011 gives even parity, 101 sends a constant 1 and 111 sends a constant 0. Any code with `par_en` = 0 sends no parity bit.
- R5: While `brk` is 1, `txd` is 0. Frame timing runs on underneath, and the line shows the frame's current level again once `brk` falls.
- R6: The queue holds `FIFO_DEPTH` bytes and sends them in write order. A write while it is full is dropped.
- R7: A `fifo_clear` cycle empties the queue. A write and a frame load in that same cycle are both dropped. A frame already on the line completes.
- R8: When the queue is not empty, a new frame is loaded on the same edge that ends the previous stop period, or on the edge after a write into an empty, idle block. The start bit appears in the following cycle.
- R9: `thr_empty` is 1 exactly when the queue is empty. `tx_idle` is 1 exactly when the queue is empty and no frame is on the line.
- R10: A change to the line-control inputs during a frame does not alter that frame. It takes effect from the next frame loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Bit-rate enable, `OVERSAMPLE` pulses per bit |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to queue |
| fifo_clear | input | 1 | Empties the transmit queue |
| word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| stop_long | input | 1 | 0: one stop bit; 1: 1.5 or 2 stop bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Parity type / stuck level select |
| par_stick | input | 1 | Constant-level parity |
| brk | input | 1 | Force line low |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | Queue empty, host may write |
| tx_idle | output | 1 | Queue empty and line idle |

## Verification
The hardest situation to reach is a queue that overflows while the engine is also popping. The stimulus slows `tick16` to one pulse every three cycles and writes eighteen bytes in consecutive cycles. Writes then meet a full queue while a load is still pending, and the dropped bytes must never appear on the line. A second hard case is a clear that lands in the same cycle as both a write and a stop period ending. The bench reaches it by timing the clear from its reference model's tick count, so the load, the write and the pending bytes must all vanish while the frame in flight still ends with its full stop length.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 2;   // start + data + parity
    localparam int NBIT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        WL5 = 2'b00,
        WL6 = 2'b01,
        WL7 = 2'b10,
        WL8 = 2'b11
    } wlen_e;

    typedef enum logic [2:0] {
        PAR_NONE,
        PAR_ODD,
        PAR_EVEN,
        PAR_ONE,
        PAR_ZERO
    } par_e;

    typedef struct packed {
        wlen_e wlen;
        logic  stop_long;
        logic  par_en;
        logic  par_even;
        logic  par_stick;
    } line_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // bit 0 leaves first
        logic [NBIT_W-1:0]  nbits;  // bits before the stop period
    } frame_t;

    function automatic int word_bits(input wlen_e w);
        return 5 + int'(w);
    endfunction

    function automatic par_e parity_mode(input line_cfg_t c);
        par_e m;
        m = PAR_NONE;
        if (c.par_en) begin
            case ({c.par_stick, c.par_even})
                2'b00:   m = PAR_ODD;
                2'b01:   m = PAR_EVEN;
                2'b10:   m = PAR_ONE;
                default: m = PAR_ZERO;
            endcase
        end
        return m;
    endfunction

    function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                        input int n, input par_e m);
        logic x;
        logic r;
        x = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) x = x ^ d[i];
        end
        case (m)
            PAR_ODD:  r = ~x;
            PAR_EVEN: r = x;
            PAR_ONE:  r = 1'b1;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                           input line_cfg_t c);
        frame_t f;
        int     n;
        par_e   m;
        logic   pb;
        n  = word_bits(c.wlen);
        m  = parity_mode(c);
        pb = parity_bit(d, n, m);
        f.bits = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) f.bits[i+1] = d[i];
        end
        for (int i = 1; i < FRAME_W; i++) begin
            if ((m != PAR_NONE) && (i == n + 1)) f.bits[i] = pb;
        end
        f.nbits = NBIT_W'((m != PAR_NONE) ? n + 2 : n + 1);
        return f;
    endfunction

    function automatic int stop_ticks(input line_cfg_t c, input int os);
        int t;
        if (!c.stop_long)        t = os;
        else if (c.wlen == WL5)  t = os + os / 2;
        else                     t = 2 * os;
        return t;
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [LW-1:0]    level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [LW-1:0]    count;
    logic             push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == LW'(DEPTH));
    assign level   = count;
    assign push_ok = push && !full && !clear;
    assign pop_ok  = pop && !empty && !clear;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + LW'(1);
                2'b01:   count <= count - LW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
    import sertx_pkg::*;
#(
    parameter int OS = 16,
    localparam int TW = $clog2(2 * OS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              avail,
    input  logic              clear,
    input  logic [DATA_W-1:0] din,
    input  line_cfg_t         cfg,
    output logic              pop,
    output logic              busy,
    output logic              line_bit
);

    logic               busy_q, in_stop;
    logic [FRAME_W-1:0] sr;
    logic [NBIT_W-1:0]  left;
    logic [TW-1:0]      tcnt, stop_lim;
    logic               stop_end, load;
    frame_t             nf;
    logic [TW-1:0]      nstop;

    always_comb begin
        nf    = build_frame(din, cfg);
        nstop = TW'(stop_ticks(cfg, OS));
    end

    assign stop_end = busy_q && in_stop && tick && (tcnt == stop_lim - TW'(1));
    assign load     = avail && !clear && (!busy_q || stop_end);
    assign pop      = load;
    assign busy     = busy_q;
    assign line_bit = (busy_q && !in_stop) ? sr[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            in_stop  <= 1'b0;
            sr       <= '0;
            left     <= '0;
            tcnt     <= '0;
            stop_lim <= '0;
        end else if (load) begin
            busy_q   <= 1'b1;
            in_stop  <= 1'b0;
            sr       <= nf.bits;
            left     <= nf.nbits;
            tcnt     <= '0;
            stop_lim <= nstop;
        end else if (stop_end) begin
            busy_q  <= 1'b0;
            in_stop <= 1'b0;
            tcnt    <= '0;
        end else if (busy_q && tick) begin
            if (in_stop) begin
                tcnt <= tcnt + TW'(1);
            end else if (tcnt == TW'(OS - 1)) begin
                tcnt <= '0;
                sr   <= sr >> 1;
                left <= left - NBIT_W'(1);
                if (left == NBIT_W'(1)) in_stop <= 1'b1;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

endmodule

// File: rtl/sertx_line.sv
module sertx_line (
    input  logic brk,
    input  logic line_bit,
    output logic txd
);

    assign txd = brk ? 1'b0 : line_bit;

endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVERSAMPLE = 16,
    localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       fifo_clear,
    input  logic [1:0] word_len,
    input  logic       stop_long,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       brk,
    output logic       txd,
    output logic       thr_empty,
    output logic       tx_idle
);

    line_cfg_t         cfg;
    logic              fifo_empty, fifo_full, pop, frame_busy, line_bit;
    logic [DATA_W-1:0] head;
    logic [LW-1:0]     fifo_level;

    always_comb begin
        cfg.wlen      = wlen_e'(word_len);
        cfg.stop_long = stop_long;
        cfg.par_en    = par_en;
        cfg.par_even  = par_even;
        cfg.par_stick = par_stick;
    end

    sertx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clear (fifo_clear),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    sertx_engine #(.OS(OVERSAMPLE)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .avail    (!fifo_empty),
        .clear    (fifo_clear),
        .din      (head),
        .cfg      (cfg),
        .pop      (pop),
        .busy     (frame_busy),
        .line_bit (line_bit)
    );

    sertx_line u_line (
        .brk      (brk),
        .line_bit (line_bit),
        .txd      (txd)
    );

    assign thr_empty = fifo_empty;
    assign tx_idle   = fifo_empty && !frame_busy;

endmodule

// File: rtl/serial_tx_framer_chk.sv
module serial_tx_framer_chk #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          fifo_clear,
    input logic          brk,
    input logic          txd,
    input logic          thr_empty,
    input logic          tx_idle,
    input logic          frame_busy,
    input logic          fifo_full,
    input logic [LW-1:0] fifo_level
);

    // R5
    break_low_chk: assert property (@(posedge clk) disable iff (rst)
        brk |-> !txd);

    // R9
    idle_implies_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> thr_empty);

    // R9
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_idle && !brk) |-> txd);

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_busy) && !brk) |-> !txd);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    // R6
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !fifo_clear) |=> (fifo_level >= LW'(DEPTH - 1)));

    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clear |=> thr_empty);

    // R8
    write_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !fifo_clear && tx_idle) |=> !thr_empty);

endmodule

bind serial_tx_framer serial_tx_framer_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .fifo_clear (fifo_clear),
    .brk        (brk),
    .txd        (txd),
    .thr_empty  (thr_empty),
    .tx_idle    (tx_idle),
    .frame_busy (frame_busy),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level)
);

// File: tb/tb_serial_tx_framer.sv
module tb_serial_tx_framer;

    localparam int DEPTH = 16;
    localparam int OS    = 16;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_clear = 1'b0;
    logic [1:0] word_len = 2'b11;
    logic       stop_long = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       brk = 1'b0;
    logic       txd, thr_empty, tx_idle;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    int    tick_period = 1;
    string tag = "R1";

    // reference model state
    byte unsigned mq[$];
    bit           m_busy = 0;
    bit           m_val[$];
    int           m_dur[$];
    int           m_idx = 0;
    int           m_cnt = 0;

    always #5 clk = ~clk;

    serial_tx_framer #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(OS)) dut (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_clear(fifo_clear), .word_len(word_len), .stop_long(stop_long),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .brk(brk),
        .txd(txd), .thr_empty(thr_empty), .tx_idle(tx_idle)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check(input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %b expected %b", tag, what, cyc, act, exp);
        end
    endtask

    // frame per requirements R2, R3, R4
    task automatic model_load(input byte unsigned d);
        int n;
        bit x;
        n = 5 + int'(word_len);
        m_val.delete();
        m_dur.delete();
        m_val.push_back(1'b0); m_dur.push_back(OS);
        x = 0;
        for (int i = 0; i < n; i++) begin
            m_val.push_back(d[i]); m_dur.push_back(OS);
            x ^= d[i];
        end
        if (par_en) begin
            if (!par_stick) m_val.push_back(par_even ? x : !x);
            else            m_val.push_back(!par_even);
            m_dur.push_back(OS);
        end
        m_val.push_back(1'b1);
        if (!stop_long)    m_dur.push_back(OS);
        else if (n == 5)   m_dur.push_back(OS + OS / 2);
        else               m_dur.push_back(2 * OS);
        m_idx  = 0;
        m_cnt  = 0;
        m_busy = 1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mq.delete();
            m_busy = 0;
        end else begin
            int pre;
            bit ending;
            pre = mq.size();
            ending = 0;
            if (m_busy && tick16) begin
                m_cnt++;
                if (m_cnt == m_dur[m_idx]) begin
                    m_cnt = 0;
                    m_idx++;
                    if (m_idx == m_dur.size()) ending = 1;
                end
            end
            if (ending) m_busy = 0;
            if ((!m_busy) && pre > 0 && !fifo_clear) model_load(mq.pop_front());
            if (fifo_clear) mq.delete();
            else if (wr_en && pre < DEPTH) mq.push_back(wr_data);
        end
        #2;
        if (cyc >= LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got cycle %0d expected < %0d", cyc, LIMIT);
            summary();
        end
        check("txd", txd, brk ? 1'b0 : (m_busy ? m_val[m_idx] : 1'b1));
        check("thr_empty", thr_empty, mq.size() == 0);
        check("tx_idle", tx_idle, (mq.size() == 0) && !m_busy);
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            tick16 <= (ph % tick_period) == 0;
        end
    end

    task automatic cfg(input logic [1:0] wl, input logic sl, input logic pe,
                       input logic pv, input logic ps);
        word_len = wl; stop_long = sl; par_en = pe; par_even = pv; par_stick = ps;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (m_busy || mq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check("txd in reset", txd, 1'b1);
        check("thr_empty in reset", thr_empty, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("tx_idle after reset", tx_idle, 1'b1);

        // R2: 8 data bits, no parity, one stop
        tag = "R2";
        cfg(2'b11, 0, 0, 0, 0);
        put(8'hA5); drain();
        put(8'h3C); drain();
        for (int w = 0; w < 3; w++) begin
            cfg(2'(w), 0, 0, 0, 0);
            put(8'h96); drain();
        end

        // R3: long stop for each word length
        tag = "R3";
        tick_period = 2;
        for (int w = 0; w < 4; w++) begin
            cfg(2'(w), 1, 0, 0, 0);
            put(8'h5B); drain();
        end
        tick_period = 1;

        // R4: every parity code
        tag = "R4";
        for (int p = 0; p < 8; p++) begin
            cfg(2'b10, 0, p[0], p[1], p[2]);
            put(8'h4D); drain();
            put(8'h01); drain();
        end

        // R5: break in the middle of a frame and released
        tag = "R5";
        cfg(2'b11, 0, 1, 1, 0);
        put(8'hF0);
        repeat (40) @(negedge clk);
        brk = 1'b1;
        repeat (60) @(negedge clk);
        brk = 1'b0;
        drain();

        // R6: overflow with slow ticks
        tag = "R6";
        tick_period = 3;
        cfg(2'b11, 0, 0, 0, 0);
        @(negedge clk);
        for (int i = 0; i < 18; i++) begin
            wr_en = 1'b1; wr_data = 8'(8'h10 + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("thr_empty with queue loaded", thr_empty, 1'b0);
        drain();
        tick_period = 1;

        // R8: back-to-back frames chained at stop end
        tag = "R8";
        cfg(2'b00, 1, 1, 0, 0);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1; wr_data = 8'(8'hC3 ^ i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        drain();

        // R7: clear mid-frame with a write in the same cycle
        tag = "R7";
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            wr_en = 1'b1; wr_data = 8'(8'h80 + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        repeat (30) @(negedge clk);
        fifo_clear = 1'b1; wr_en = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        fifo_clear = 1'b0; wr_en = 1'b0;
        drain();

        // R7: clear on the edge that ends a stop period
        put(8'h11); put(8'h22); put(8'h33);
        while (!(m_busy && m_idx == m_dur.size() - 1 && m_cnt == m_dur[m_idx] - 1))
            @(negedge clk);
        fifo_clear = 1'b1; wr_en = 1'b1; wr_data = 8'h44;
        @(negedge clk);
        fifo_clear = 1'b0; wr_en = 1'b0;
        drain();

        // R10: configuration changes during a frame
        tag = "R10";
        cfg(2'b11, 0, 1, 0, 0);
        put(8'h7E);
        repeat (50) @(negedge clk);
        cfg(2'b00, 1, 0, 0, 0);
        repeat (10) @(negedge clk);
        put(8'h7E);
        drain();

        // R9: status after all traffic
        tag = "R9";
        check("thr_empty final", thr_empty, 1'b1);
        check("tx_idle final", tx_idle, 1'b1);
        check("txd final", txd, 1'b1);
        summary();
    end

endmodule